// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge and Vector Unit

This block owns the request and in-service state of two 8-line interrupt controllers, one primary and one secondary. The secondary feeds the primary through primary line 2. Separate priority resolvers, outside this block, read the request, in-service and rotation-base outputs. Each resolver returns a winner flag and a winning line number.

When the CPU raises a one-cycle acknowledge strobe, the unit commits the winners. It marks them in service and drops latched edge requests. On the following cycle it presents an 8-bit vector for one cycle. The vector is a programmed 5-bit base tag above a 3-bit line number.

Cases with no winner return line 7 of the relevant controller as a spurious vector. Automatic end-of-interrupt can be selected, with or without priority rotation. The CPU interrupt output is a registered copy of the primary resolver's winner flag, and it drops for one cycle after each acknowledge.

The vector output is a data stream of one word per acknowledge. It has a valid flag and no ready input. There is no back-pressure: the consumer must take the word in the single cycle its valid flag is high. Every other pin is plain control or status.

Top module: `iav_ack_unit`

## Requirements
- R1: An edge-mode line (mode bit 0) sets its request bit one cycle after its input goes from 0 to 1, and keeps the bit when the input falls. A level-mode line (mode bit 1) has a request bit that equals its input of the previous cycle.
- R2: Primary line 2 is fed only by the cascade. A secondary winner flag high in a cycle with no acknowledge sets primary request bit 2 on the next cycle, as a latched edge. The primary request input bit 2 and the primary mode bit 2 have no effect.
- R3: Without automatic end-of-interrupt, an acknowledge with a primary winner sets the in-service bit of the winning line.
- R4: On acknowledge, the request bit of the winning line is cleared if it is edge mode. It stays set if it is level mode with its input still high.
- R5: When the primary winner is line 2 and the secondary has a winner, both are acknowledged. The vector is {secondary base tag, secondary line}.
- R6: When the primary winner is line 2 and the secondary has no winner, the vector is {secondary base tag, 3'd7}. Secondary in-service state is unchanged.
- R7: With no primary winner, the vector is {primary base tag, 3'd7}, and no in-service bit changes.
- R8: The vector valid flag is high exactly in the cycle after each acknowledge strobe. The vector's upper 5 bits are the base tag and its low 3 bits are the line.
- R9: With automatic end-of-interrupt on, an acknowledge leaves the in-service registers unchanged. The rotation base changes only when rotation is also enabled.
- R10: With automatic end-of-interrupt and rotation both on, each acknowledged controller's rotation base becomes (line+1) mod 8, so line 7 gives 0.
- R11: The interrupt output is low in the cycle after an acknowledge. In every other cycle it equals the primary winner flag of the previous cycle.
- R12: After reset, all request, in-service and rotation registers, the interrupt output and the vector valid flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_req_i | input | 8 | Primary request pins (bit 2 unused) |
| slv_req_i | input | 8 | Secondary request pins |
| mst_level_i | input | 8 | Primary trigger mode, 1 = level |
| slv_level_i | input | 8 | Secondary trigger mode, 1 = level |
| mst_win_valid_i | input | 1 | Primary resolver has a grantable line |
| mst_win_line_i | input | 3 | Primary winning line |
| slv_win_valid_i | input | 1 | Secondary resolver has a grantable line |
| slv_win_line_i | input | 3 | Secondary winning line |
| mst_base_i | input | 5 | Primary vector base tag |
| slv_base_i | input | 5 | Secondary vector base tag |
| auto_eoi_i | input | 1 | Automatic end-of-interrupt enable |
| rot_aeoi_i | input | 1 | Rotate on automatic end-of-interrupt |
| ack_i | input | 1 | One-cycle acknowledge strobe |
| vec_o | output | 8 | Vector number |
| vec_valid_o | output | 1 | Vector valid, one cycle |
| int_o | output | 1 | Interrupt request to CPU |
| mst_irr_o | output | 8 | Primary request register |
| mst_isr_o | output | 8 | Primary in-service register |
| slv_irr_o | output | 8 | Secondary request register |
| slv_isr_o | output | 8 | Secondary in-service register |
| mst_rot_o | output | 3 | Primary rotation base |
| slv_rot_o | output | 3 | Secondary rotation base |

## Verification
The acknowledge path is driven with five kinds of winner pattern:
- a direct primary line;
- a cascaded pair;
- a cascade with no secondary winner;
- no primary winner at all;
- the same lines with automatic end-of-interrupt, with and without rotation.

These separate the four vector sources from each other, and they separate in-service setting from its automatic clearing. Request capture is tried with edge-mode and level-mode lines held high across an acknowledge, which tells clearing apart from re-latching. The cascade line is tried with its own pin and mode bit asserted, which shows that only the secondary winner feeds it. Rotation is tried on line 4 and then on line 7 to expose the wrap to 0.

// File: rtl/iav_pkg.sv
`timescale 1ns/1ps
package iav_pkg;
  typedef enum logic [1:0] {
    SRC_NONE     = 2'd0,
    SRC_PRIMARY  = 2'd1,
    SRC_CASCADE  = 2'd2,
    SRC_CASC_SPU = 2'd3
  } iav_src_e;
endpackage

// File: rtl/iav_chan.sv
`timescale 1ns/1ps
module iav_chan #(
  parameter int LINES = 8,
  parameter logic [LINES-1:0] CASC_MASK = '0,
  localparam int LW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_i,
  input  logic [LINES-1:0] level_i,
  input  logic             casc_set_i,
  input  logic             ack_i,
  input  logic [LW-1:0]    ack_line_i,
  input  logic             aeoi_i,
  input  logic             rot_aeoi_i,
  output logic [LINES-1:0] irr_o,
  output logic [LINES-1:0] isr_o,
  output logic [LW-1:0]    rot_o
);
  logic [LINES-1:0] last_q, irr_d, isr_d, last_d;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic hit, rise, lvl;
    assign hit  = ack_i && (ack_line_i == LW'(i));
    assign lvl  = CASC_MASK[i] ? 1'b0 : level_i[i];
    assign rise = CASC_MASK[i] ? casc_set_i : (req_i[i] & ~last_q[i]);
    assign irr_d[i]  = lvl ? req_i[i] : ((irr_o[i] & ~hit) | rise);
    assign isr_d[i]  = isr_o[i] | (hit & ~aeoi_i);
    assign last_d[i] = CASC_MASK[i] ? 1'b0 : req_i[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_o  <= '0;
      isr_o  <= '0;
      last_q <= '0;
      rot_o  <= '0;
    end else begin
      irr_o  <= irr_d;
      isr_o  <= isr_d;
      last_q <= last_d;
      if (ack_i && aeoi_i && rot_aeoi_i) rot_o <= ack_line_i + 1'b1;
    end
  end
endmodule

// File: rtl/iav_vector.sv
`timescale 1ns/1ps
module iav_vector
  import iav_pkg::*;
#(
  parameter int LINES = 8,
  parameter int VEC_W = 8,
  parameter int CASC_LINE = 2,
  localparam int LW = $clog2(LINES),
  localparam int BW = VEC_W - LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_i,
  input  logic             mst_valid_i,
  input  logic [LW-1:0]    mst_line_i,
  input  logic             slv_valid_i,
  input  logic [LW-1:0]    slv_line_i,
  input  logic [BW-1:0]    mst_base_i,
  input  logic [BW-1:0]    slv_base_i,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_valid_o
);
  iav_src_e src;
  logic [VEC_W-1:0] vec_d;

  always_comb begin
    if (!mst_valid_i)                          src = SRC_NONE;
    else if (mst_line_i != LW'(CASC_LINE))     src = SRC_PRIMARY;
    else if (slv_valid_i)                      src = SRC_CASCADE;
    else                                       src = SRC_CASC_SPU;
    unique case (src)
      SRC_PRIMARY:  vec_d = {mst_base_i, mst_line_i};
      SRC_CASCADE:  vec_d = {slv_base_i, slv_line_i};
      SRC_CASC_SPU: vec_d = {slv_base_i, {LW{1'b1}}};
      default:      vec_d = {mst_base_i, {LW{1'b1}}};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_o       <= '0;
      vec_valid_o <= 1'b0;
    end else begin
      vec_valid_o <= ack_i;
      if (ack_i) vec_o <= vec_d;
    end
  end
endmodule

// File: rtl/iav_ack_unit.sv
`timescale 1ns/1ps
module iav_ack_unit #(
  parameter int LINES = 8,
  parameter int VEC_W = 8,
  parameter int CASC_LINE = 2,
  localparam int LW = $clog2(LINES),
  localparam int BW = VEC_W - LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] mst_req_i,
  input  logic [LINES-1:0] slv_req_i,
  input  logic [LINES-1:0] mst_level_i,
  input  logic [LINES-1:0] slv_level_i,
  input  logic             mst_win_valid_i,
  input  logic [LW-1:0]    mst_win_line_i,
  input  logic             slv_win_valid_i,
  input  logic [LW-1:0]    slv_win_line_i,
  input  logic [BW-1:0]    mst_base_i,
  input  logic [BW-1:0]    slv_base_i,
  input  logic             auto_eoi_i,
  input  logic             rot_aeoi_i,
  input  logic             ack_i,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_valid_o,
  output logic             int_o,
  output logic [LINES-1:0] mst_irr_o,
  output logic [LINES-1:0] mst_isr_o,
  output logic [LINES-1:0] slv_irr_o,
  output logic [LINES-1:0] slv_isr_o,
  output logic [LW-1:0]    mst_rot_o,
  output logic [LW-1:0]    slv_rot_o
);
  localparam logic [LINES-1:0] MST_CASC = LINES'(1) << CASC_LINE;

  logic mst_ack, slv_ack, casc_set;

  assign mst_ack  = ack_i && mst_win_valid_i;
  assign slv_ack  = mst_ack && (mst_win_line_i == LW'(CASC_LINE)) && slv_win_valid_i;
  // forwarding is held off while an acknowledge commits; resolvers re-evaluate next cycle
  assign casc_set = slv_win_valid_i && !ack_i;

  iav_chan #(.LINES(LINES), .CASC_MASK(MST_CASC)) u_mst (
    .clk(clk), .rst_n(rst_n), .req_i(mst_req_i), .level_i(mst_level_i),
    .casc_set_i(casc_set), .ack_i(mst_ack), .ack_line_i(mst_win_line_i),
    .aeoi_i(auto_eoi_i), .rot_aeoi_i(rot_aeoi_i),
    .irr_o(mst_irr_o), .isr_o(mst_isr_o), .rot_o(mst_rot_o)
  );

  iav_chan #(.LINES(LINES), .CASC_MASK('0)) u_slv (
    .clk(clk), .rst_n(rst_n), .req_i(slv_req_i), .level_i(slv_level_i),
    .casc_set_i(1'b0), .ack_i(slv_ack), .ack_line_i(slv_win_line_i),
    .aeoi_i(auto_eoi_i), .rot_aeoi_i(rot_aeoi_i),
    .irr_o(slv_irr_o), .isr_o(slv_isr_o), .rot_o(slv_rot_o)
  );

  iav_vector #(.LINES(LINES), .VEC_W(VEC_W), .CASC_LINE(CASC_LINE)) u_vec (
    .clk(clk), .rst_n(rst_n), .ack_i(ack_i),
    .mst_valid_i(mst_win_valid_i), .mst_line_i(mst_win_line_i),
    .slv_valid_i(slv_win_valid_i), .slv_line_i(slv_win_line_i),
    .mst_base_i(mst_base_i), .slv_base_i(slv_base_i),
    .vec_o(vec_o), .vec_valid_o(vec_valid_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) int_o <= 1'b0;
    else        int_o <= mst_win_valid_i && !ack_i;
  end
endmodule

// File: rtl/iav_ack_chk.sv
`timescale 1ns/1ps
module iav_ack_chk #(
  parameter int LINES = 8,
  parameter int VEC_W = 8,
  parameter int CASC_LINE = 2,
  localparam int LW = $clog2(LINES),
  localparam int BW = VEC_W - LW
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LINES-1:0] mst_req_i,
  input logic [LINES-1:0] mst_level_i,
  input logic             mst_win_valid_i,
  input logic [LW-1:0]    mst_win_line_i,
  input logic [BW-1:0]    mst_base_i,
  input logic             auto_eoi_i,
  input logic             rot_aeoi_i,
  input logic             ack_i,
  input logic [VEC_W-1:0] vec_o,
  input logic             vec_valid_o,
  input logic             int_o,
  input logic [LINES-1:0] mst_irr_o,
  input logic [LINES-1:0] mst_isr_o,
  input logic [LINES-1:0] slv_isr_o,
  input logic [LW-1:0]    mst_rot_o
);
  logic [LW-1:0] line_inc;
  logic          lvl_hold;
  assign line_inc = mst_win_line_i + 1'b1;
  assign lvl_hold = mst_level_i[mst_win_line_i] && mst_req_i[mst_win_line_i]
                    && (mst_win_line_i != LW'(CASC_LINE));

  p_isr_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && mst_win_valid_i && !auto_eoi_i |=> mst_isr_o[$past(mst_win_line_i)]);

  p_level_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && mst_win_valid_i && lvl_hold |=> mst_irr_o[$past(mst_win_line_i)]);

  p_spur_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && !mst_win_valid_i |=> vec_o == {$past(mst_base_i), {LW{1'b1}}}
                                  && $stable(mst_isr_o) && $stable(slv_isr_o));

  p_vec_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> vec_valid_o);

  p_vec_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> !vec_valid_o);

  p_aeoi_isr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && auto_eoi_i |=> $stable(mst_isr_o) && $stable(slv_isr_o));

  p_rot_base_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && mst_win_valid_i && auto_eoi_i && rot_aeoi_i |=> mst_rot_o == $past(line_inc));

  p_int_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> !int_o);

  p_int_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> int_o == $past(mst_win_valid_i));
endmodule

bind iav_ack_unit iav_ack_chk #(.LINES(LINES), .VEC_W(VEC_W), .CASC_LINE(CASC_LINE)) u_chk (.*);

// File: tb/iav_ack_unit_tb.sv
`timescale 1ns/1ps
module iav_ack_unit_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] mst_req_i = '0, slv_req_i = '0, mst_level_i = '0, slv_level_i = '0;
  logic mst_win_valid_i = 0, slv_win_valid_i = 0, auto_eoi_i = 0, rot_aeoi_i = 0, ack_i = 0;
  logic [2:0] mst_win_line_i = '0, slv_win_line_i = '0;
  logic [4:0] mst_base_i = 5'h04, slv_base_i = 5'h0E;
  logic [7:0] vec_o, mst_irr_o, mst_isr_o, slv_irr_o, slv_isr_o;
  logic vec_valid_o, int_o;
  logic [2:0] mst_rot_o, slv_rot_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  iav_ack_unit u_dut (.*);

  typedef struct packed {
    logic mv; logic [2:0] ml; logic sv; logic [2:0] sl;
    logic aeoi; logic rot; logic [7:0] vec; logic [7:0] misr; logic [7:0] sisr;
    logic [2:0] mrot; logic [2:0] srot;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{1'b1, 3'd3, 1'b0, 3'd0, 1'b0, 1'b0, 8'h23, 8'h08, 8'h00, 3'd0, 3'd0}, // R3 direct
    '{1'b1, 3'd2, 1'b1, 3'd5, 1'b0, 1'b0, 8'h75, 8'h04, 8'h20, 3'd0, 3'd0}, // R5 cascade
    '{1'b1, 3'd2, 1'b0, 3'd0, 1'b0, 1'b0, 8'h77, 8'h04, 8'h00, 3'd0, 3'd0}, // R6 casc spurious
    '{1'b0, 3'd4, 1'b0, 3'd0, 1'b0, 1'b0, 8'h27, 8'h00, 8'h00, 3'd0, 3'd0}, // R7 none
    '{1'b1, 3'd6, 1'b0, 3'd0, 1'b1, 1'b0, 8'h26, 8'h00, 8'h00, 3'd0, 3'd0}, // R9 aeoi
    '{1'b1, 3'd6, 1'b0, 3'd0, 1'b1, 1'b1, 8'h26, 8'h00, 8'h00, 3'd7, 3'd0}, // R10 rotate
    '{1'b1, 3'd2, 1'b1, 3'd1, 1'b1, 1'b1, 8'h71, 8'h00, 8'h00, 3'd3, 3'd2}, // R10 cascade rot
    '{1'b1, 3'd0, 1'b0, 3'd0, 1'b0, 1'b0, 8'h20, 8'h01, 8'h00, 3'd0, 3'd0}  // R8 line 0
  };

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; ack_i = 0; mst_win_valid_i = 0; slv_win_valid_i = 0;
    mst_req_i = '0; slv_req_i = '0; mst_level_i = '0; slv_level_i = '0;
    auto_eoi_i = 0; rot_aeoi_i = 0;
    step(); step();
    rst_n = 1;
    step();
  endtask

  task automatic ack(logic mv, logic [2:0] ml, logic sv, logic [2:0] sl);
    mst_win_valid_i = mv; mst_win_line_i = ml;
    slv_win_valid_i = sv; slv_win_line_i = sl;
    ack_i = 1; step(); ack_i = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R12 reset state
    do_reset();
    chk("R12 mst_irr", 16'(mst_irr_o), 16'h0);
    chk("R12 isr", 16'({mst_isr_o, slv_isr_o}), 16'h0);
    chk("R12 rot/int/valid", 16'({mst_rot_o, slv_rot_o, int_o, vec_valid_o}), 16'h0);

    // table of acknowledge cases
    foreach (TBL[k]) begin
      do_reset();
      auto_eoi_i = TBL[k].aeoi; rot_aeoi_i = TBL[k].rot;
      ack(TBL[k].mv, TBL[k].ml, TBL[k].sv, TBL[k].sl);
      chk("R8 vec", 16'(vec_o), 16'(TBL[k].vec));
      chk("R8 valid", 16'(vec_valid_o), 16'h1);
      chk("R11 int after ack", 16'(int_o), 16'h0);
      chk("R3/R9 mst_isr", 16'(mst_isr_o), 16'(TBL[k].misr));
      chk("R5/R6 slv_isr", 16'(slv_isr_o), 16'(TBL[k].sisr));
      chk("R10 mst_rot", 16'(mst_rot_o), 16'(TBL[k].mrot));
      chk("R10 slv_rot", 16'(slv_rot_o), 16'(TBL[k].srot));
      mst_win_valid_i = 0; slv_win_valid_i = 0;
    end

    // R1 edge vs level capture; line 4 level, line 5 edge
    do_reset();
    mst_level_i = 8'h10;
    mst_req_i = 8'h20; step();
    chk("R1 edge set", 16'(mst_irr_o[5]), 16'h1);
    mst_req_i = 8'h00; step();
    chk("R1 edge held", 16'(mst_irr_o[5]), 16'h1);
    mst_req_i = 8'h10; step();
    chk("R1 level set", 16'(mst_irr_o[4]), 16'h1);
    mst_req_i = 8'h00; step();
    chk("R1 level follows", 16'(mst_irr_o[4]), 16'h0);

    // R4 clear on ack for edge line, keep for level line
    mst_req_i = 8'h10; step();
    ack(1'b1, 3'd5, 1'b0, 3'd0);
    chk("R4 edge cleared", 16'(mst_irr_o[5]), 16'h0);
    chk("R3 isr5", 16'(mst_isr_o[5]), 16'h1);
    ack(1'b1, 3'd4, 1'b0, 3'd0);
    chk("R4 level kept", 16'(mst_irr_o[4]), 16'h1);
    mst_win_valid_i = 0;

    // R2 cascade line fed only by secondary winner
    do_reset();
    mst_level_i = 8'h04; mst_req_i = 8'h04;
    step(); step();
    chk("R2 pin ignored", 16'(mst_irr_o[2]), 16'h0);
    slv_win_valid_i = 1; step();
    chk("R2 cascade set", 16'(mst_irr_o[2]), 16'h1);
    slv_win_valid_i = 0; step();
    chk("R2 cascade latched", 16'(mst_irr_o[2]), 16'h1);

    // R10 wrap
    do_reset();
    auto_eoi_i = 1; rot_aeoi_i = 1;
    ack(1'b1, 3'd4, 1'b0, 3'd0);
    chk("R10 rot line4", 16'(mst_rot_o), 16'h5);
    ack(1'b1, 3'd7, 1'b0, 3'd0);
    chk("R10 rot wrap", 16'(mst_rot_o), 16'h0);
    chk("R9 isr untouched", 16'(mst_isr_o), 16'h0);

    // R11 interrupt output tracking
    do_reset();
    mst_win_valid_i = 1; mst_win_line_i = 3'd1; step();
    chk("R11 int follows", 16'(int_o), 16'h1);
    ack_i = 1; step(); ack_i = 0;
    chk("R11 int drop", 16'(int_o), 16'h0);
    step();
    chk("R11 int back", 16'(int_o), 16'h1);
    chk("R8 valid one cycle", 16'(vec_valid_o), 16'h0);
    mst_win_valid_i = 0; step();
    chk("R11 int low", 16'(int_o), 16'h0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule